// File: doc/BRIEF.md
# SPI User-Command Transfer Engine

This block is a register-driven SPI master for a serial flash port. Software loads a shared 64-byte data buffer through 32-bit word writes and programs the number of bits to move. It then writes a start command. The engine asserts chip select and shifts the requested bits out most-significant bit first. When input capture is on, it samples MISO on the same clock and overwrites the transmitted bits in the buffer with the received ones. At the end of the transfer it raises a sticky completion flag, which software polls before it reads the buffer back.

A frame-hold control can keep chip select asserted after a transfer ends. Software uses this to split a long flash transaction into buffer-sized chunks that the device sees as one frame. The serial clock rate is set outside the block: each shift phase moves forward only on a one-cycle enable tick from an external divider. The serial bus runs in SPI mode 0. MOSI changes on the falling edge and MISO is captured on the rising edge.

Top module: `spi_usercmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, the register at offset 0x30 reads 0 and the engine is idle.
- R2: Writing offset 0x00 with bit 18 set starts a transfer when the engine is idle. spi_cs_n goes low and spi_sck gives exactly N+1 rising edges, where N is the field at bits [25:17] of offset 0x20.
- R3: Bit k of a transfer is bit 7-(k mod 8) of buffer byte k/8. Byte b is bits [8(b mod 4)+7 : 8(b mod 4)] of the word at offset 0x40+4(b/4). MOSI is stable while spi_sck is high and changes only on its falling edge.
- R4: When bit 0 of offset 0x1c is 1, the MISO value sampled at rising edge k replaces buffer bit k at the position given in R3, and bits past N keep their loaded value. When bit 0 is 0, the buffer is left unchanged.
- R5: Bit 4 of offset 0x30 is set at the last falling edge of a transfer and stays set until software writes it to 0.
- R6: If bit 30 of offset 0x2c is 1 when a transfer ends, spi_cs_n stays low afterwards. If the bit is 0, spi_cs_n returns to 1.
- R7: A start command written while a transfer is running has no effect. The running transfer still gives exactly N+1 clock edges.
- R8: If bit 27 of offset 0x1c is 0, a start command produces no clock edge and does not assert chip select, and the done flag (bit 4 of 0x30) is set at once.
- R9: While bit 30 of offset 0x30 is 1 (non-master mode), a start command is ignored: no clock edges, chip select stays high, and the done flag stays clear.
- R10: Writing offset 0x30 with bit 31 set aborts any transfer, releases chip select, forces spi_sck low and clears the done flag. Bit 31 always reads back 0.
- R11: spi_sck changes level only on a clock cycle where sclk_tick is high. With sclk_tick held low, a started transfer stays frozen with chip select asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 7 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sclk_tick | input | 1 | One-cycle enable that advances one serial clock phase |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench goes after bit counts that are not a multiple of eight, the one-bit and full-buffer extremes, and the lane order of received bytes in each word. A bit-index or lane error would show up as scrambled readback or a wrong edge count. It also issues a second start in the middle of a transfer, which a design that restarts would answer with extra clock edges. Soft reset in the middle of a frame, non-master mode, a start with no data stage, and a frozen tick are each probed at the pins. Each of these would show up as a chip select left low, a lost or spurious done flag, or clock edges where none belong.

// File: rtl/spiu_pkg.sv
package spiu_pkg;

   localparam int ADDR_W = 7;
   localparam int DATA_W = 32;

   // register offsets (byte addresses)
   localparam logic [ADDR_W-1:0] OFS_CMD   = 7'h00;
   localparam logic [ADDR_W-1:0] OFS_STAGE = 7'h1c;
   localparam logic [ADDR_W-1:0] OFS_COUNT = 7'h20;
   localparam logic [ADDR_W-1:0] OFS_FRAME = 7'h2c;
   localparam logic [ADDR_W-1:0] OFS_MODE  = 7'h30;

   // field positions
   localparam int GO_BIT     = 18;
   localparam int DIN_BIT    = 0;
   localparam int DOUT_BIT   = 27;
   localparam int COUNT_LSB  = 17;
   localparam int HOLD_BIT   = 30;
   localparam int DONE_BIT   = 4;
   localparam int SLAVE_BIT  = 30;
   localparam int SRST_BIT   = 31;

   typedef struct packed {
      logic din_en;
      logic dout_sel;
      logic cs_hold;
      logic slave_mode;
   } spiu_ctl_t;

endpackage

// File: rtl/spiu_regs.sv
module spiu_regs
   import spiu_pkg::*;
#(
   parameter int WORDS = 16,
   parameter int CNT_W = 9
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic [DATA_W-1:0]       buf_rd_word,
   output logic                    buf_wr,
   output logic [$clog2(WORDS)-1:0] buf_idx,
   input  logic                    finish,
   output logic                    go,
   output logic                    srst,
   output spiu_ctl_t               ctl,
   output logic [CNT_W-1:0]        bit_last,
   output logic                    done_flag
);

   localparam int WIDX_W = $clog2(WORDS);

   logic is_buf;
   logic in_range;
   logic wr_stage, wr_count, wr_frame, wr_mode;

   assign is_buf  = bus_addr[ADDR_W-1];
   assign buf_idx = bus_addr[2 +: WIDX_W];

   generate
      if (WIDX_W < 4) begin : g_partial_window
         assign in_range = (bus_addr[5:2+WIDX_W] == '0);
      end else begin : g_full_window
         assign in_range = 1'b1;
      end
   endgenerate

   assign buf_wr   = bus_wr && is_buf && in_range;
   assign wr_stage = bus_wr && (bus_addr == OFS_STAGE);
   assign wr_count = bus_wr && (bus_addr == OFS_COUNT);
   assign wr_frame = bus_wr && (bus_addr == OFS_FRAME);
   assign wr_mode  = bus_wr && (bus_addr == OFS_MODE);
   assign go       = bus_wr && (bus_addr == OFS_CMD) && bus_wdata[GO_BIT];
   assign srst     = wr_mode && bus_wdata[SRST_BIT];

   logic unused_addr_bits;
   assign unused_addr_bits = ^bus_addr[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl      <= '0;
         bit_last <= '0;
      end else begin
         if (wr_stage) begin
            ctl.din_en   <= bus_wdata[DIN_BIT];
            ctl.dout_sel <= bus_wdata[DOUT_BIT];
         end
         if (wr_count) bit_last   <= bus_wdata[COUNT_LSB +: CNT_W];
         if (wr_frame) ctl.cs_hold <= bus_wdata[HOLD_BIT];
         if (wr_mode)  ctl.slave_mode <= bus_wdata[SLAVE_BIT];
      end
   end

   // done: soft reset first, then engine completion, then software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       done_flag <= 1'b0;
      else if (srst)    done_flag <= 1'b0;
      else if (finish)  done_flag <= 1'b1;
      else if (wr_mode) done_flag <= bus_wdata[DONE_BIT];
   end

   always_comb begin
      bus_rdata = '0;
      if (is_buf) begin
         if (in_range) bus_rdata = buf_rd_word;
      end else begin
         case (bus_addr)
            OFS_STAGE: begin
               bus_rdata[DIN_BIT]  = ctl.din_en;
               bus_rdata[DOUT_BIT] = ctl.dout_sel;
            end
            OFS_COUNT: bus_rdata[COUNT_LSB +: CNT_W] = bit_last;
            OFS_FRAME: bus_rdata[HOLD_BIT] = ctl.cs_hold;
            OFS_MODE: begin
               bus_rdata[SLAVE_BIT] = ctl.slave_mode;
               bus_rdata[DONE_BIT]  = done_flag;
            end
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/spiu_buffer.sv
module spiu_buffer
   import spiu_pkg::*;
#(
   parameter int WORDS = 16,
   parameter int CNT_W = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(WORDS)-1:0] wr_idx,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [$clog2(WORDS)-1:0] rd_idx,
   output logic [DATA_W-1:0]        rd_word,
   input  logic                     bit_we,
   input  logic [CNT_W-1:0]         bit_idx,
   input  logic                     bit_val,
   input  logic [CNT_W-1:0]         tx_idx,
   output logic                     tx_bit
);

   localparam int WIDX_W = $clog2(WORDS);
   localparam int NBYTES = WORDS * 4;

   logic [DATA_W-1:0] mem [WORDS];
   logic [7:0]        byte_q [NBYTES];

   // per-byte view: byte b sits in lane b%4 of word b/4
   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_lane
         assign byte_q[b] = mem[b/4][8*(b%4) +: 8];
      end
   endgenerate

   logic [WIDX_W-1:0] bw_word;
   logic [4:0]        bw_pos;

   // serial bit k -> byte k/8, bit 7-(k%8)
   assign bw_word = bit_idx[CNT_W-1:5];
   assign bw_pos  = {bit_idx[4:3], ~bit_idx[2:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else begin
         for (int w = 0; w < WORDS; w++) begin
            if (wr_en && (wr_idx == WIDX_W'(w)))
               mem[w] <= wr_data;
            else if (bit_we && (bw_word == WIDX_W'(w)))
               mem[w][bw_pos] <= bit_val;
         end
      end
   end

   assign rd_word = mem[rd_idx];
   assign tx_bit  = byte_q[tx_idx[CNT_W-1:3]][~tx_idx[2:0]];

endmodule

// File: rtl/spiu_shifter.sv
module spiu_shifter
   import spiu_pkg::*;
#(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             go,
   input  spiu_ctl_t        ctl,
   input  logic [CNT_W-1:0] bit_last,
   input  logic             tick,
   input  logic             miso,
   input  logic             tx_bit,
   output logic [CNT_W-1:0] tx_idx,
   output logic             rx_we,
   output logic [CNT_W-1:0] rx_idx,
   output logic             rx_val,
   output logic             sck,
   output logic             mosi,
   output logic             busy,
   output logic             held,
   output logic             finish
);

   logic [CNT_W-1:0] idx;
   logic launch;
   logic rise_now;
   logic fall_now;
   logic last_fall;

   assign launch    = go && !busy && !ctl.slave_mode;
   assign rise_now  = busy && tick && !sck;
   assign fall_now  = busy && tick && sck;
   assign last_fall = fall_now && (idx == bit_last);
   assign finish    = last_fall || (launch && !ctl.dout_sel);

   // next bit fetched ahead of its falling edge; bit 0 fetched at launch
   assign tx_idx = busy ? idx + 1'b1 : '0;
   assign rx_we  = rise_now && ctl.din_en;
   assign rx_idx = idx;
   assign rx_val = miso;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sck  <= 1'b0;
         mosi <= 1'b0;
         held <= 1'b0;
         idx  <= '0;
      end else if (srst) begin
         busy <= 1'b0;
         sck  <= 1'b0;
         mosi <= 1'b0;
         held <= 1'b0;
         idx  <= '0;
      end else if (launch && ctl.dout_sel) begin
         busy <= 1'b1;
         sck  <= 1'b0;
         idx  <= '0;
         mosi <= tx_bit;
      end else if (rise_now) begin
         sck <= 1'b1;
      end else if (fall_now) begin
         sck <= 1'b0;
         if (last_fall) begin
            busy <= 1'b0;
            mosi <= 1'b0;
            held <= ctl.cs_hold;
         end else begin
            idx  <= idx + 1'b1;
            mosi <= tx_bit;
         end
      end
   end

endmodule

// File: rtl/spi_usercmd_engine.sv
module spi_usercmd_engine
   import spiu_pkg::*;
#(
   parameter int BUF_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [6:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              sclk_tick,
   output logic              spi_sck,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   localparam int WORDS  = BUF_BYTES / 4;
   localparam int WIDX_W = $clog2(WORDS);
   localparam int CNT_W  = WIDX_W + 5;

   generate
      if (BUF_BYTES < 8 || BUF_BYTES > 64 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_size
         $error("BUF_BYTES must be a power of two between 8 and 64");
      end
      if (COUNT_LSB + CNT_W > DATA_W) begin : g_bad_count
         $error("bit-count field does not fit its register");
      end
   endgenerate

   spiu_ctl_t         ctl;
   logic [CNT_W-1:0]  bit_last;
   logic              go, srst, finish, done_flag, busy, held;
   logic              buf_wr;
   logic [WIDX_W-1:0] buf_idx;
   logic [31:0]       buf_rd_word;
   logic              rx_we, rx_val, tx_bit;
   logic [CNT_W-1:0]  rx_idx, tx_idx;

   spiu_regs #(.WORDS(WORDS), .CNT_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .buf_rd_word(buf_rd_word),
      .buf_wr     (buf_wr),
      .buf_idx    (buf_idx),
      .finish     (finish),
      .go         (go),
      .srst       (srst),
      .ctl        (ctl),
      .bit_last   (bit_last),
      .done_flag  (done_flag)
   );

   spiu_buffer #(.WORDS(WORDS), .CNT_W(CNT_W)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (buf_wr),
      .wr_idx (buf_idx),
      .wr_data(bus_wdata),
      .rd_idx (buf_idx),
      .rd_word(buf_rd_word),
      .bit_we (rx_we),
      .bit_idx(rx_idx),
      .bit_val(rx_val),
      .tx_idx (tx_idx),
      .tx_bit (tx_bit)
   );

   spiu_shifter #(.CNT_W(CNT_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst    (srst),
      .go      (go),
      .ctl     (ctl),
      .bit_last(bit_last),
      .tick    (sclk_tick),
      .miso    (spi_miso),
      .tx_bit  (tx_bit),
      .tx_idx  (tx_idx),
      .rx_we   (rx_we),
      .rx_idx  (rx_idx),
      .rx_val  (rx_val),
      .sck     (spi_sck),
      .mosi    (spi_mosi),
      .busy    (busy),
      .held    (held),
      .finish  (finish)
   );

   assign spi_cs_n = !(busy || held);

endmodule

// File: rtl/spiu_checker.sv
module spiu_checker (
   input logic clk,
   input logic rst_n,
   input logic sclk_tick,
   input logic spi_sck,
   input logic spi_cs_n,
   input logic spi_mosi,
   input logic busy,
   input logic done_flag,
   input logic srst
);

   AST_SCK_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sck) |-> $past(sclk_tick));                          // R11

   AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));            // R3

   AST_CS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !spi_cs_n);                                           // R2

   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !spi_sck);                                           // R2

   AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(srst)) |-> done_flag);                  // R5

   AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(srst) |-> (!done_flag && !busy && !spi_sck));            // R10

endmodule

bind spi_usercmd_engine spiu_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sclk_tick(sclk_tick),
   .spi_sck  (spi_sck),
   .spi_cs_n (spi_cs_n),
   .spi_mosi (spi_mosi),
   .busy     (busy),
   .done_flag(done_flag),
   .srst     (srst)
);

// File: tb/spi_usercmd_engine_test.sv
module spi_usercmd_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sclk_tick = 1'b0;
   logic        spi_sck, spi_cs_n, spi_mosi;
   logic        spi_miso = 1'b0;

   spi_usercmd_engine uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_tick(sclk_tick),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso)
   );

   always #10 clk = ~clk;   // 50 MHz

   int  n_chk = 0;
   int  n_bad = 0;
   bit  summary_done = 0;
   bit  tick_en = 1;
   logic [7:0] txb [64];
   bit  rxp [512];
   bit  cap [512];
   int  rises = 0;
   int  cs_low = 0;
   logic sck_q = 1'b0;

   always @(negedge clk) sclk_tick <= tick_en && ($urandom_range(0, 2) != 0);

   // slave model: capture MOSI at each rising edge, present next MISO bit
   always @(negedge clk) begin
      if (spi_sck && !sck_q) begin
         if (rises < 512) cap[rises] = spi_mosi;
         rises++;
         if (rises < 512) spi_miso = rxp[rises];
      end
      sck_q = spi_sck;
      if (!spi_cs_n) cs_low++;
   end

   task automatic finish_run();
      if (!summary_done) begin
         summary_done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = a;
      #2 d = bus_rdata;
   endtask

   function automatic logic [31:0] tx_word(input int w);
      return {txb[4*w+3], txb[4*w+2], txb[4*w+1], txb[4*w]};
   endfunction

   function automatic bit tx_bit_k(input int k);
      return txb[k/8][7 - (k % 8)];
   endfunction

   function automatic logic [31:0] exp_word(input int w, input bit din, input int nlast);
      logic [31:0] r;
      for (int b = 0; b < 4; b++)
         for (int p = 0; p < 8; p++) begin
            int k;
            k = 8 * (4*w + b) + 7 - p;
            r[8*b+p] = (din && k <= nlast) ? rxp[k] : txb[4*w+b][p];
         end
      return r;
   endfunction

   task automatic randomize_data();
      for (int i = 0; i < 64; i++) txb[i] = 8'($urandom);
      for (int i = 0; i < 512; i++) rxp[i] = 1'($urandom);
   endtask

   task automatic setup(input int nlast, input bit din, input bit hold);
      for (int w = 0; w < 16; w++) wr(7'h40 + 7'(4*w), tx_word(w));
      wr(7'h1c, (32'd1 << 27) | 32'(din));
      wr(7'h20, 32'(nlast) << 17);
      wr(7'h2c, 32'(hold) << 30);
      wr(7'h30, 32'd0);
      rises = 0;
      spi_miso = rxp[0];
   endtask

   task automatic wait_done(output bit ok);
      logic [31:0] d;
      ok = 0;
      for (int i = 0; i < 30000; i++) begin
         rd(7'h30, d);
         if (d[4]) begin ok = 1; break; end
      end
   endtask

   task automatic run_xfer(input int nlast, input bit din, input bit hold, input bit dbl);
      bit ok;
      int bad;
      logic [31:0] d;
      setup(nlast, din, hold);
      wr(7'h00, 32'd1 << 18);
      if (dbl) begin
         repeat (6) @(negedge clk);
         wr(7'h00, 32'd1 << 18);
      end
      wait_done(ok);
      chk(ok, "R5", "done flag set", ok, 1);
      chk(rises == nlast + 1, dbl ? "R7" : "R2", "sck rising edges", rises, nlast + 1);
      bad = 0;
      for (int k = 0; k <= nlast; k++) if (cap[k] != tx_bit_k(k)) bad++;
      chk(bad == 0, "R3", "mosi bits wrong", bad, 0);
      bad = 0;
      for (int w = 0; w < 16; w++) begin
         rd(7'h40 + 7'(4*w), d);
         if (d != exp_word(w, din, nlast)) begin
            bad++;
            chk(0, "R4", $sformatf("buffer word %0d", w), d, exp_word(w, din, nlast));
         end
      end
      chk(bad == 0, "R4", "buffer words wrong", bad, 0);
      chk(spi_cs_n == !hold, "R6", "cs_n after end", spi_cs_n, !hold);
      rd(7'h30, d);
      chk(d[4] == 1'b1, "R5", "done still set", d[4], 1);
      wr(7'h30, 32'd0);
      rd(7'h30, d);
      chk(d[4] == 1'b0, "R5", "done cleared by write", d[4], 0);
   endtask

   initial begin
      logic [31:0] d;
      bit ok;
      int snap;
      void'($urandom(32'h5eed_1234));
      randomize_data();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
      chk(spi_sck == 1'b0, "R1", "sck after reset", spi_sck, 0);
      rd(7'h30, d);
      chk(d == 0, "R1", "status after reset", d, 0);

      // directed extremes
      run_xfer(0, 1, 0, 0);
      randomize_data(); run_xfer(511, 1, 0, 0);
      randomize_data(); run_xfer(12, 1, 1, 0);
      randomize_data(); run_xfer(23, 0, 0, 0);
      randomize_data(); run_xfer(15, 0, 0, 1);    // R7 second start

      // constrained random transfers
      for (int t = 0; t < 22; t++) begin
         int nb, nl;
         randomize_data();
         nb = $urandom_range(1, 64);
         nl = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 8*nb - 1) : 8*nb - 1;
         run_xfer(nl, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 5) == 0));
      end

      // R11: frozen tick holds the frame
      randomize_data();
      tick_en = 0;
      setup(7, 1, 0);
      wr(7'h00, 32'd1 << 18);
      repeat (30) @(negedge clk);
      chk(rises == 0, "R11", "edges with tick low", rises, 0);
      chk(spi_cs_n == 1'b0, "R11", "cs_n frozen frame", spi_cs_n, 0);
      tick_en = 1;
      wait_done(ok);
      chk(ok && rises == 8, "R11", "edges after tick resumes", rises, 8);

      // R10: soft reset mid-frame with hold set
      randomize_data();
      setup(200, 1, 1);
      wr(7'h00, 32'd1 << 18);
      repeat (30) @(negedge clk);
      wr(7'h30, 32'd1 << 31);
      chk(spi_cs_n == 1'b1, "R10", "cs_n after soft reset", spi_cs_n, 1);
      chk(spi_sck == 1'b0, "R10", "sck after soft reset", spi_sck, 0);
      rd(7'h30, d);
      chk(d == 0, "R10", "status after soft reset", d, 0);
      snap = rises;
      repeat (40) @(negedge clk);
      chk(rises == snap, "R10", "edges after abort", rises, snap);

      // R9: non-master mode ignores start
      setup(7, 0, 0);
      wr(7'h30, 32'd1 << 30);
      cs_low = 0;
      wr(7'h00, 32'd1 << 18);
      repeat (40) @(negedge clk);
      chk(rises == 0, "R9", "edges in slave mode", rises, 0);
      chk(cs_low == 0, "R9", "cs low cycles in slave mode", cs_low, 0);
      rd(7'h30, d);
      chk(d == (32'd1 << 30), "R9", "status in slave mode", d, 32'd1 << 30);
      wr(7'h30, 32'd0);

      // R8: no data-out stage
      setup(31, 0, 0);
      wr(7'h1c, 32'd0);
      cs_low = 0;
      wr(7'h00, 32'd1 << 18);
      rd(7'h30, d);
      chk(d[4] == 1'b1, "R8", "done with no data stage", d[4], 1);
      repeat (20) @(negedge clk);
      chk(rises == 0, "R8", "edges with no data stage", rises, 0);
      chk(cs_low == 0, "R8", "cs low cycles no data stage", cs_low, 0);

      finish_run();
   end

endmodule